// File: doc/BRIEF.md
# Card Reader Ready, Stop and Reset Sequencer

This block decides when a card-reader transport may be told it is ready. After power comes up it holds a long power-on reset, timed in clock ticks, so that the blower motor can reach speed. The block moves to the ready state only after the operator presses and then lets go of the reset pushbutton. While the button is held down, the block drives the initialisation reset for the pick and column logic. It also drives a combined signal, power-on reset OR operator reset, to the error logic.

While a card is moving through the read station, the block holds a reset-inhibit flag. The read-cycle start strobe sets this flag and the end-of-card strobe clears it. While the flag is set, both pushbuttons are ignored.

READY drops on any check from the error logic. It also drops when the operator presses the stop pushbutton outside a read cycle. A drop caused by the stop button lights a stop indicator, which stays lit until the next reset press that the block accepts. The shutdown selector has two positions. In automatic mode, a hopper-empty check switches the blower off. The next accepted reset press and release then switches the blower back on and starts the full power-on reset again. In manual mode the blower runs whenever the block is out of power reset.

Top module: `rdr_ready_ctrl`

## Requirements
- R1: After `pwr_rst_n` deasserts, `por_o` stays high for exactly TICKS_PER_MS*POR_MS clock cycles and then falls. While `por_o` is high, `por_or_rst_o` is high and `ready_o` is low.
- R2: Each pushbutton passes through SYNC_STAGES flip-flops. While an accepted reset press is held, `init_rst_o` and `por_or_rst_o` are both high.
- R3: When an accepted reset press is released, `ready_o` goes high, provided the blower is not shut down and no hopper check is present.
- R4: If `hopper_chk` is high when the reset button is released, `ready_o` stays low.
- R5: A stop press while `rst_inhibit_o` is low clears `ready_o`. If `ready_o` was high at that moment, the press also sets `stop_ind_o`. The next accepted reset press clears `stop_ind_o`.
- R6: A high level on any bit of `check_in`, or on `hopper_chk`, clears `ready_o` on the next clock edge.
- R7: A one-cycle pulse on `cyc_start` sets `rst_inhibit_o` and a pulse on `cyc_end` clears it. While it is set, stop presses leave `ready_o` unchanged, and reset presses raise neither `init_rst_o` nor `por_or_rst_o`.
- R8: When `auto_shutdown` is 1 and `hopper_chk` is high, `blower_en_o` goes low. The next accepted reset release raises `blower_en_o` and restarts a full-length `por_o`. `ready_o` stays low until a further release after that power-on reset ends.
- R9: When `auto_shutdown` is 0, `blower_en_o` stays high outside power reset, whatever the state of `hopper_chk`.
- R10: Reset presses and releases made while `por_o` is high are ignored. `init_rst_o` stays low and `ready_o` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_rst_n | input | 1 | Asynchronous power-present reset, active low |
| reset_btn | input | 1 | Reset pushbutton, high while pressed, asynchronous |
| stop_btn | input | 1 | Stop pushbutton, high while pressed, asynchronous |
| check_in | input | N_CHECKS | Check flags from the error logic, any bit high is a check |
| hopper_chk | input | 1 | Hopper-empty check |
| cyc_start | input | 1 | Read-cycle start strobe |
| cyc_end | input | 1 | End-of-card strobe |
| auto_shutdown | input | 1 | 1 = automatic blower shutdown, 0 = manual |
| por_o | output | 1 | Power-on reset in progress |
| init_rst_o | output | 1 | Pick and column initialisation reset |
| por_or_rst_o | output | 1 | Power-on reset OR accepted operator reset, to error logic |
| ready_o | output | 1 | Reader ready to the controlling device |
| rst_inhibit_o | output | 1 | Read cycle in progress, pushbuttons masked |
| blower_en_o | output | 1 | Blower motor enable |
| stop_ind_o | output | 1 | Stop indicator lamp |

## Verification
The release-to-ready path is exercised under five conditions:
- a clean release;
- a release after a stop press;
- a release with a hopper check held in manual mode;
- a release that first has to restart the power-on reset after an automatic shutdown;
- releases made during power-on reset.

Each condition checks a different gate on the READY set term. Stop and reset presses are repeated with the inhibit flag set and again after it clears. This shows that only the inhibit flag, and not the button timing, decides whether a press is masked. The restart path checks the power-on reset length a second time, which separates a restart from a counter that merely resumes.

// File: rtl/rdr_ctrl_pkg.sv
package rdr_ctrl_pkg;

   // Bit positions of the pushbuttons inside the synchroniser bus
   localparam int unsigned BTN_RESET = 0;
   localparam int unsigned BTN_STOP  = 1;
   localparam int unsigned BTN_COUNT = 2;

   // Width of a counter that must hold values 0..n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rdr_sync.sv
module rdr_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rdr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rdr_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= '0;
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], din};
      end
   end

   assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/rdr_por_timer.sv
module rdr_por_timer
   import rdr_ctrl_pkg::*;
#(
   parameter int unsigned POR_CYCLES = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic por
);

   localparam int unsigned CW = cnt_width(POR_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

   if (POR_CYCLES < 2) begin : g_bad_len
      $error("rdr_por_timer: POR_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          por_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         por_q <= 1'b1;
      end else if (restart) begin
         cnt_q <= '0;
         por_q <= 1'b1;
      end else if (por_q) begin
         if (cnt_q == LAST) begin
            por_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign por = por_q;

endmodule

// File: rtl/rdr_cycle_guard.sv
module rdr_cycle_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic por,
   input  logic cyc_start,
   input  logic cyc_end,
   input  logic rst_s,
   output logic inhibit,
   output logic accept_hold,
   output logic release_evt
);

   logic inhibit_q;
   logic armed_q;

   // Read-cycle flag: start wins over end in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inhibit_q <= 1'b0;
      end else if (por) begin
         inhibit_q <= 1'b0;
      end else if (cyc_start) begin
         inhibit_q <= 1'b1;
      end else if (cyc_end) begin
         inhibit_q <= 1'b0;
      end
   end

   // A press counts only outside a read cycle and outside power-on reset
   assign accept_hold = rst_s & ~inhibit_q & ~por;

   // Registered edge detector on the accepted hold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else begin
         armed_q <= accept_hold;
      end
   end

   assign release_evt = armed_q & ~rst_s & ~inhibit_q;
   assign inhibit     = inhibit_q;

endmodule

// File: rtl/rdr_status.sv
module rdr_status #(
   parameter int unsigned N_CHECKS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                por,
   input  logic                accept_hold,
   input  logic                release_evt,
   input  logic                stop_s,
   input  logic                inhibit,
   input  logic [N_CHECKS-1:0] check_in,
   input  logic                hopper_chk,
   input  logic                auto_shutdown,
   output logic                ready,
   output logic                stop_ind,
   output logic                blower_en,
   output logic                por_restart
);

   logic blower_off_q;
   logic ready_q;
   logic stop_ind_q;
   logic any_check;
   logic stop_ok;
   logic ready_clr;
   logic ready_set;

   if (N_CHECKS == 1) begin : g_one_check
      assign any_check = check_in[0] | hopper_chk;
   end else begin : g_many_check
      assign any_check = (|check_in) | hopper_chk;
   end

   assign stop_ok     = stop_s & ~inhibit;
   assign por_restart = release_evt & blower_off_q;
   assign ready_clr   = por | any_check | stop_ok;
   assign ready_set   = release_evt & ~blower_off_q & ~hopper_chk;

   // Blower shutdown latch: release restarts, manual mode never shuts down
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blower_off_q <= 1'b0;
      end else if (!auto_shutdown) begin
         blower_off_q <= 1'b0;
      end else if (por_restart) begin
         blower_off_q <= 1'b0;
      end else if (hopper_chk) begin
         blower_off_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
      end else if (ready_clr) begin
         ready_q <= 1'b0;
      end else if (ready_set) begin
         ready_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_ind_q <= 1'b0;
      end else if (accept_hold) begin
         stop_ind_q <= 1'b0;
      end else if (ready_q && stop_ok) begin
         stop_ind_q <= 1'b1;
      end
   end

   assign ready     = ready_q;
   assign stop_ind  = stop_ind_q;
   assign blower_en = ~blower_off_q;

endmodule

// File: rtl/rdr_ready_ctrl.sv
module rdr_ready_ctrl
   import rdr_ctrl_pkg::*;
#(
   parameter int unsigned TICKS_PER_MS = 1000,
   parameter int unsigned POR_MS       = 3000,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned N_CHECKS     = 2
) (
   input  logic                clk,
   input  logic                pwr_rst_n,
   input  logic                reset_btn,
   input  logic                stop_btn,
   input  logic [N_CHECKS-1:0] check_in,
   input  logic                hopper_chk,
   input  logic                cyc_start,
   input  logic                cyc_end,
   input  logic                auto_shutdown,
   output logic                por_o,
   output logic                init_rst_o,
   output logic                por_or_rst_o,
   output logic                ready_o,
   output logic                rst_inhibit_o,
   output logic                blower_en_o,
   output logic                stop_ind_o
);

   localparam int unsigned POR_CYCLES = TICKS_PER_MS * POR_MS;

   if (TICKS_PER_MS < 1 || POR_MS < 1) begin : g_bad_time
      $error("rdr_ready_ctrl: TICKS_PER_MS and POR_MS must be nonzero");
   end
   if (N_CHECKS < 1) begin : g_bad_checks
      $error("rdr_ready_ctrl: N_CHECKS must be at least 1");
   end

   logic [BTN_COUNT-1:0] btn_raw;
   logic [BTN_COUNT-1:0] btn_s;
   logic por;
   logic por_restart;
   logic inhibit;
   logic accept_hold;
   logic release_evt;

   assign btn_raw[BTN_RESET] = reset_btn;
   assign btn_raw[BTN_STOP]  = stop_btn;

   rdr_sync #(
      .WIDTH  (BTN_COUNT),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (pwr_rst_n),
      .din   (btn_raw),
      .dout  (btn_s)
   );

   rdr_por_timer #(
      .POR_CYCLES (POR_CYCLES)
   ) u_por (
      .clk     (clk),
      .rst_n   (pwr_rst_n),
      .restart (por_restart),
      .por     (por)
   );

   rdr_cycle_guard u_guard (
      .clk         (clk),
      .rst_n       (pwr_rst_n),
      .por         (por),
      .cyc_start   (cyc_start),
      .cyc_end     (cyc_end),
      .rst_s       (btn_s[BTN_RESET]),
      .inhibit     (inhibit),
      .accept_hold (accept_hold),
      .release_evt (release_evt)
   );

   rdr_status #(
      .N_CHECKS (N_CHECKS)
   ) u_status (
      .clk           (clk),
      .rst_n         (pwr_rst_n),
      .por           (por),
      .accept_hold   (accept_hold),
      .release_evt   (release_evt),
      .stop_s        (btn_s[BTN_STOP]),
      .inhibit       (inhibit),
      .check_in      (check_in),
      .hopper_chk    (hopper_chk),
      .auto_shutdown (auto_shutdown),
      .ready         (ready_o),
      .stop_ind      (stop_ind_o),
      .blower_en     (blower_en_o),
      .por_restart   (por_restart)
   );

   assign por_o         = por;
   assign init_rst_o    = accept_hold;
   assign por_or_rst_o  = por | accept_hold;
   assign rst_inhibit_o = inhibit;

endmodule

// File: rtl/rdr_ready_ctrl_chk.sv
module rdr_ready_ctrl_chk #(
   parameter int unsigned N_CHECKS = 2
) (
   input logic                clk,
   input logic                pwr_rst_n,
   input logic [N_CHECKS-1:0] check_in,
   input logic                hopper_chk,
   input logic                auto_shutdown,
   input logic                por_o,
   input logic                init_rst_o,
   input logic                por_or_rst_o,
   input logic                ready_o,
   input logic                rst_inhibit_o,
   input logic                blower_en_o,
   input logic                stop_ind_o
);

   assert_por_no_ready_R1: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      por_o |-> (!ready_o && por_or_rst_o));

   assert_por_masks_reset_R10: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      por_o |-> !init_rst_o);

   assert_init_reaches_err_R2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      init_rst_o |-> por_or_rst_o);

   assert_ready_needs_no_hopper_R3: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      $rose(ready_o) |-> !$past(hopper_chk));

   assert_check_drops_ready_R6: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (|check_in) |=> !ready_o);

   assert_inhibit_masks_reset_R7: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      rst_inhibit_o |-> !init_rst_o);

   assert_inhibit_holds_ready_R7: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (rst_inhibit_o && ready_o && !(|check_in) && !hopper_chk && !por_o) |=> ready_o);

   assert_stop_ind_after_drop_R5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      $rose(stop_ind_o) |-> !ready_o);

   assert_manual_blower_R9: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      !auto_shutdown |-> blower_en_o);

endmodule

bind rdr_ready_ctrl rdr_ready_ctrl_chk #(.N_CHECKS(N_CHECKS)) u_chk (
   .clk           (clk),
   .pwr_rst_n     (pwr_rst_n),
   .check_in      (check_in),
   .hopper_chk    (hopper_chk),
   .auto_shutdown (auto_shutdown),
   .por_o         (por_o),
   .init_rst_o    (init_rst_o),
   .por_or_rst_o  (por_or_rst_o),
   .ready_o       (ready_o),
   .rst_inhibit_o (rst_inhibit_o),
   .blower_en_o   (blower_en_o),
   .stop_ind_o    (stop_ind_o)
);

// File: tb/tb_rdr_ready_ctrl.sv
module tb_rdr_ready_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int TPM        = 4;
   localparam int PMS        = 3;
   localparam int NCHK       = 2;
   localparam int POR_LEN    = TPM * PMS;

   logic clk = 1'b0;
   logic pwr_rst_n = 1'b0;
   logic reset_btn = 1'b0;
   logic stop_btn = 1'b0;
   logic [NCHK-1:0] check_in = '0;
   logic hopper_chk = 1'b0;
   logic cyc_start = 1'b0;
   logic cyc_end = 1'b0;
   logic auto_shutdown = 1'b0;
   logic por_o, init_rst_o, por_or_rst_o, ready_o, rst_inhibit_o, blower_en_o, stop_ind_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rdr_ready_ctrl #(
      .TICKS_PER_MS (TPM),
      .POR_MS       (PMS),
      .SYNC_STAGES  (2),
      .N_CHECKS     (NCHK)
   ) dut (
      .clk           (clk),
      .pwr_rst_n     (pwr_rst_n),
      .reset_btn     (reset_btn),
      .stop_btn      (stop_btn),
      .check_in      (check_in),
      .hopper_chk    (hopper_chk),
      .cyc_start     (cyc_start),
      .cyc_end       (cyc_end),
      .auto_shutdown (auto_shutdown),
      .por_o         (por_o),
      .init_rst_o    (init_rst_o),
      .por_or_rst_o  (por_or_rst_o),
      .ready_o       (ready_o),
      .rst_inhibit_o (rst_inhibit_o),
      .blower_en_o   (blower_en_o),
      .stop_ind_o    (stop_ind_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic press_release();
      reset_btn = 1'b1;
      wait_cyc(5);
      reset_btn = 1'b0;
      wait_cyc(5);
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
      wait_cyc(2);
   endtask

   // R1, R10: power-on reset length, and reset presses ignored during it
   task automatic t_power_up();
      int cnt;
      wait_cyc(3);
      check("R1 reset ready", int'(ready_o), 0);
      check("R1 reset por", int'(por_o), 1);
      check("R1 reset por_or_rst", int'(por_or_rst_o), 1);
      check("R9 reset blower", int'(blower_en_o), 1);
      check("R5 reset stop_ind", int'(stop_ind_o), 0);
      check("R7 reset inhibit", int'(rst_inhibit_o), 0);
      reset_btn = 1'b1;
      pwr_rst_n = 1'b1;
      #1;
      cnt = 0;
      for (int i = 0; i < POR_LEN + 10; i++) begin
         if (por_o) cnt++;
         if (i == 4) check("R10 init_rst masked during por", int'(init_rst_o), 0);
         if (i == 6) reset_btn = 1'b0;
         @(negedge clk);
      end
      check("R1 por length", cnt, POR_LEN);
      check("R10 ready after por with early release", int'(ready_o), 0);
      check("R1 por_or_rst after por", int'(por_or_rst_o), 0);
   endtask

   // R2, R3: clean press and release
   task automatic t_reset_ready();
      reset_btn = 1'b1;
      wait_cyc(5);
      check("R2 init_rst held", int'(init_rst_o), 1);
      check("R2 por_or_rst held", int'(por_or_rst_o), 1);
      check("R3 ready low while held", int'(ready_o), 0);
      reset_btn = 1'b0;
      wait_cyc(5);
      check("R3 ready after release", int'(ready_o), 1);
      check("R2 init_rst released", int'(init_rst_o), 0);
   endtask

   // R7: inhibit masks stop and reset; then R5: stop outside a cycle
   task automatic t_inhibit_stop();
      pulse(cyc_start);
      check("R7 inhibit set", int'(rst_inhibit_o), 1);
      stop_btn = 1'b1;
      wait_cyc(5);
      check("R7 stop ignored ready", int'(ready_o), 1);
      check("R7 stop ignored lamp", int'(stop_ind_o), 0);
      stop_btn = 1'b0;
      wait_cyc(3);
      reset_btn = 1'b1;
      wait_cyc(5);
      check("R7 reset ignored init", int'(init_rst_o), 0);
      check("R7 reset ignored combined", int'(por_or_rst_o), 0);
      reset_btn = 1'b0;
      wait_cyc(5);
      check("R7 ready after masked reset", int'(ready_o), 1);
      pulse(cyc_end);
      check("R7 inhibit cleared", int'(rst_inhibit_o), 0);
      stop_btn = 1'b1;
      wait_cyc(5);
      check("R5 stop drops ready", int'(ready_o), 0);
      check("R5 stop lamp on", int'(stop_ind_o), 1);
      stop_btn = 1'b0;
      wait_cyc(3);
      reset_btn = 1'b1;
      wait_cyc(5);
      check("R5 stop lamp cleared by reset", int'(stop_ind_o), 0);
      reset_btn = 1'b0;
      wait_cyc(5);
      check("R3 ready after stop recovery", int'(ready_o), 1);
   endtask

   // R6, R4, R9: checks drop READY; hopper blocks READY; manual blower
   task automatic t_checks();
      check_in = 2'b10;
      @(negedge clk);
      check_in = '0;
      wait_cyc(2);
      check("R6 check bit drops ready", int'(ready_o), 0);
      press_release();
      check("R3 ready after check cleared", int'(ready_o), 1);
      auto_shutdown = 1'b0;
      hopper_chk = 1'b1;
      wait_cyc(3);
      check("R6 hopper drops ready", int'(ready_o), 0);
      check("R9 manual blower stays on", int'(blower_en_o), 1);
      press_release();
      check("R4 hopper blocks ready", int'(ready_o), 0);
      check("R9 manual blower after release", int'(blower_en_o), 1);
      hopper_chk = 1'b0;
      press_release();
      check("R3 ready after hopper cleared", int'(ready_o), 1);
   endtask

   // R8: automatic shutdown and por restart
   task automatic t_auto_shutdown();
      int cnt;
      int waited;
      auto_shutdown = 1'b1;
      hopper_chk = 1'b1;
      wait_cyc(3);
      check("R8 blower off in auto", int'(blower_en_o), 0);
      check("R6 ready off on hopper", int'(ready_o), 0);
      hopper_chk = 1'b0;
      wait_cyc(2);
      check("R8 blower stays off after hopper clears", int'(blower_en_o), 0);
      reset_btn = 1'b1;
      wait_cyc(5);
      reset_btn = 1'b0;
      waited = 0;
      while (!por_o && waited < 10) begin
         @(negedge clk);
         waited++;
      end
      check("R8 por restarted", int'(por_o), 1);
      check("R8 blower back on", int'(blower_en_o), 1);
      cnt = 0;
      for (int i = 0; i < POR_LEN + 5; i++) begin
         if (por_o) cnt++;
         @(negedge clk);
      end
      check("R8 restarted por length", cnt, POR_LEN);
      check("R8 ready low after restart", int'(ready_o), 0);
      press_release();
      check("R8 ready after second release", int'(ready_o), 1);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      t_power_up();
      t_reset_ready();
      t_inhibit_stop();
      t_checks();
      t_auto_shutdown();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule